// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This unit sits beside one channel of a descriptor-based DMA engine and decides when that channel interrupts the processor. It does not raise an interrupt for every finished packet. It counts packet completions down from a programmable threshold and raises a completion event when the count runs out. It also restarts a programmable one-shot delay timer on every completion. When that timer runs out without another completion arriving, it raises a delay event, so a trickle of traffic below the threshold is still reported.

Each event latches into a sticky pending bit. Software clears a pending bit by writing one to its position in the status word. Each pending bit is gated by an enable bit from the control word, and the gated bits drive a single level-sensitive interrupt line. The live counter and timer values are returned in the upper bytes of the status read word, so software can see how close each event is. The control and status registers live in the surrounding register block. This unit receives the decoded control fields, a status write strobe with the write-one-to-clear bits, a packet-complete pulse and a prescaled timer tick.

Top module: `dma_irq_coalesce`

## Requirements
- R1: Synchronous active-low reset clears both pending bits, the timer and the interrupt line, and sets the completion counter to 1. Completion pulses during reset are ignored.
- R2: A completion pulse with no control write in the same cycle decrements the counter by one. The counter appears in status read bits 23:16.
- R3: A completion that takes the counter from 1 to 0 does three things: it sets the completion-pending bit (status bit 12), reloads the counter from the threshold (control bits 23:16), and leaves 0 unseen.
- R4: A control write reloads the counter from the threshold. In the same cycle it takes priority over a completion's decrement.
- R5: A completion when the delay field (control bits 31:24) is nonzero reloads the timer with the delay value, restarting it even if it is running. A completion when the delay field is zero leaves the timer untouched.
- R6: A running timer (value not 0) decrements once per prescale tick and holds without a tick. It appears in status read bits 31:24. A timer at 0 stays at 0.
- R7: A tick that takes the timer from 1 to 0 sets the delay-pending bit (status bit 13) and reloads the counter from the threshold. This happens unless the same cycle carries a completion or control write, which then decides the counter.
- R8: A status write clears each pending bit whose write-data bit is 1 (data bit 12 for completion, 13 for delay). A 0 leaves the bit unchanged.
- R9: If a pending bit is set and cleared in the same cycle, it ends up set.
- R10: The interrupt output is high exactly when a pending bit is set and its enable bit is set. The enable field is control bits 14:12, with bit 12 for completion and bit 13 for delay. Bit 14 has no pending source and can never raise the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_done | input | 1 | One-cycle pulse per completed packet |
| ctrl_wr | input | 1 | Control-register write strobe (reloads counter) |
| cfg_thresh | input | 8 | Completion threshold (control bits 23:16) |
| cfg_delay | input | 8 | Delay timer load value (control bits 31:24) |
| cfg_irq_en | input | 3 | Interrupt enables (control bits 14:12) |
| sts_wr | input | 1 | Status-register write strobe |
| sts_w1c | input | 2 | Status write data bits 13:12 (1 clears) |
| tick | input | 1 | Timer prescale tick |
| pend | output | 2 | Pending bits: [0] completion, [1] delay |
| cnt_live | output | 8 | Live completion counter |
| tmr_live | output | 8 | Live delay timer value |
| sts_rdata | output | 32 | Status read view: timer, counter, pending bits |
| irq | output | 1 | Level interrupt request |

## Verification
Assertions check these rules on every cycle:
- the counter holds when it has no cause to change, and a control write always lands the threshold in it;
- the timer holds without a tick and is restarted with the delay by a completion;
- a set always beats a clear on a pending bit;
- a rising pending bit always traces back to the counter or the timer reaching its last step.

The bench scenarios cover the effects that need a sequence of cycles:
- the exact counter and timer values after a series of completions and ticks;
- the timer restarting on completions that come between ticks;
- the reload on expiry;
- masking through each enable bit, including the sourceless bit 14;
- priority of a control write over a completion in the same cycle.

// File: rtl/irqc_pkg.sv
// irqc_pkg: shared field positions of the coalescing unit's status word.
// Assumes the surrounding register block keeps these positions in its map.
package irqc_pkg;
    localparam int CMP_BIT   = 12;   // completion-pending position in status
    localparam int DLY_BIT   = 13;   // delay-pending position in status
    localparam int NPEND     = 2;    // number of pending sources
    localparam int EN_W      = 3;    // width of the interrupt field
    localparam int CNT_LSB   = 16;   // live counter position in status
    localparam int TMR_LSB   = 24;   // live timer position in status
endpackage

// File: rtl/irqc_counter.sv
// irqc_counter: completion down-counter with threshold reload.
// Assumes dec is a one-cycle pulse; a load has priority over dec, and dec over
// the expiry reload. hit pulses when a decrement takes the count from 1 to 0.
module irqc_counter #(
    parameter int CNT_W   = 8,
    parameter int RST_CNT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic             reld,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Last-step detect: a decrement not overridden by a control write
    always_comb hit = dec && !load && (cnt == ONE);

    // Count register: reload on write, hit or expiry; otherwise step down
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= CNT_W'(RST_CNT);
        else if (load)        cnt <= thresh;
        else if (dec) begin
            if (cnt == ONE)   cnt <= thresh;
            else              cnt <= cnt - ONE;
        end
        else if (reld)        cnt <= thresh;
    end

    p_reload_on_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(thresh)));
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec && !reld) |=> $stable(cnt));
endmodule

// File: rtl/irqc_timer.sv
// irqc_timer: one-shot delay timer restarted by each completion.
// Assumes tick is the prescaled time base. A start with a zero delay is
// ignored. expire pulses on the tick that takes the value from 1 to 0.
module irqc_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMR_W-1:0] dly,
    input  logic             tick,
    output logic [TMR_W-1:0] tmr,
    output logic             expire
);
    localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
    localparam logic [TMR_W-1:0] ZERO = '0;

    logic restart;

    // Restart condition: completion with a nonzero delay
    always_comb restart = start && (dly != ZERO);
    // Expiry: last tick of a run not cut short by a restart
    always_comb expire = tick && (tmr == ONE) && !restart;

    // Timer register: load on restart, step down on ticks while running
    always_ff @(posedge clk) begin
        if (!rst_n)                      tmr <= ZERO;
        else if (restart)                tmr <= dly;
        else if (tick && tmr != ZERO)    tmr <= tmr - ONE;
    end

    p_tmr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dly != ZERO) |=> (tmr == $past(dly)));
    p_tmr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(tmr));
endmodule

// File: rtl/irqc_pending.sv
// irqc_pending: sticky pending bits with write-one-to-clear.
// Assumes set and clr are already qualified; set wins over clr per bit.
module irqc_pending #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit: set dominates clear, otherwise hold
        always_ff @(posedge clk) begin
            if (!rst_n)        pend[i] <= 1'b0;
            else if (set[i])   pend[i] <= 1'b1;
            else if (clr[i])   pend[i] <= 1'b0;
        end

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]);
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/dma_irq_coalesce.sv
// dma_irq_coalesce: per-channel interrupt coalescing for a DMA engine.
// It combines a completion counter, a one-shot delay timer and the
// sticky pending bits into one level interrupt and a status read view.
// Assumes control fields are stable between writes and pkt_done is a pulse.
module dma_irq_coalesce
    import irqc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TMR_W   = 8,
    parameter int RST_CNT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [TMR_W-1:0] cfg_delay,
    input  logic [EN_W-1:0]  cfg_irq_en,
    input  logic             sts_wr,
    input  logic [NPEND-1:0] sts_w1c,
    input  logic             tick,
    output logic [NPEND-1:0] pend,
    output logic [CNT_W-1:0] cnt_live,
    output logic [TMR_W-1:0] tmr_live,
    output logic [31:0]      sts_rdata,
    output logic             irq
);
    localparam int PAD_W = EN_W - NPEND;

    logic             cmp_hit;
    logic             tmr_exp;
    logic [NPEND-1:0] pset;
    logic [NPEND-1:0] pclr;

    irqc_counter #(.CNT_W(CNT_W), .RST_CNT(RST_CNT)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctrl_wr),
        .dec    (pkt_done),
        .reld   (tmr_exp),
        .thresh (cfg_thresh),
        .cnt    (cnt_live),
        .hit    (cmp_hit)
    );

    irqc_timer #(.TMR_W(TMR_W)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pkt_done),
        .dly    (cfg_delay),
        .tick   (tick),
        .tmr    (tmr_live),
        .expire (tmr_exp)
    );

    // Event and clear vectors in pending-bit order (completion, delay)
    always_comb begin
        pset = {tmr_exp, cmp_hit};
        pclr = sts_wr ? sts_w1c : '0;
    end

    irqc_pending #(.N(NPEND)) i_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pset),
        .clr   (pclr),
        .pend  (pend)
    );

    // Interrupt: any enabled pending bit; the top enable has no source
    always_comb irq = |({{PAD_W{1'b0}}, pend} & cfg_irq_en);

    // Status read view: timer, counter, pending bits at their positions
    always_comb begin
        sts_rdata = '0;
        sts_rdata[CMP_BIT] = pend[0];
        sts_rdata[DLY_BIT] = pend[1];
        sts_rdata[CNT_LSB +: CNT_W] = cnt_live;
        sts_rdata[TMR_LSB +: TMR_W] = tmr_live;
    end

    p_cmp_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> ($past(pkt_done) && $past(cnt_live) == CNT_W'(1)));
    p_dly_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> ($past(tick) && $past(tmr_live) == TMR_W'(1)));
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en[1:0] == 2'b00) |-> !irq);
endmodule

// File: tb/test_dma_irq_coalesce.sv
`timescale 1ns/1ps
module test_dma_irq_coalesce;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_done = 1'b0, ctrl_wr = 1'b0, sts_wr = 1'b0, tick = 1'b0;
    logic [7:0] cfg_thresh = 8'd0, cfg_delay = 8'd0;
    logic [2:0] cfg_irq_en = 3'd0;
    logic [1:0] sts_w1c = 2'd0;
    logic [1:0] pend;
    logic [7:0] cnt_live, tmr_live;
    logic [31:0] sts_rdata;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_coalesce i_dma_irq_coalesce (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .ctrl_wr(ctrl_wr),
        .cfg_thresh(cfg_thresh), .cfg_delay(cfg_delay), .cfg_irq_en(cfg_irq_en),
        .sts_wr(sts_wr), .sts_w1c(sts_w1c), .tick(tick), .pend(pend),
        .cnt_live(cnt_live), .tmr_live(tmr_live), .sts_rdata(sts_rdata), .irq(irq)
    );

    typedef struct packed {
        logic       cw;
        logic [7:0] thr;
        logic [7:0] dly;
        logic [2:0] en;
        logic       pk;
        logic       tk;
        logic       sw;
        logic [1:0] w1c;
        logic [1:0] e_pend;
        logic [7:0] e_cnt;
        logic [7:0] e_tmr;
        logic       e_irq;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd3, 8'd4, 3'b011, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 8'd3, 8'd0, 1'b0, 4'd4 },  // R4 write reloads
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 8'd2, 8'd4, 1'b0, 4'd2 },  // R2 R5 decrement, timer start
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 8'd2, 8'd3, 1'b0, 4'd6 },  // R6 tick
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 8'd2, 8'd3, 1'b0, 4'd6 },  // R6 hold
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 8'd1, 8'd4, 1'b0, 4'd5 },  // R5 restart
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 8'd3, 8'd4, 1'b1, 4'd3 },  // R3 threshold hit
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 8'd2, 8'd4, 1'b1, 4'd2 },  // R2
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b01, 8'd2, 8'd3, 1'b1, 4'd6 },  // R6
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b01, 8'd2, 8'd2, 1'b1, 4'd6 },  // R6
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b01, 8'd2, 8'd1, 1'b1, 4'd6 },  // R6
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b11, 8'd3, 8'd0, 1'b1, 4'd7 },  // R7 expiry
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b11, 8'd3, 8'd0, 1'b1, 4'd6 },  // R6 stays at 0
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b0, 1'b1, 2'b01, 2'b10, 8'd3, 8'd0, 1'b1, 4'd8 },  // R8 clear completion
        '{1'b0, 8'd3, 8'd4, 3'b011, 1'b0, 1'b0, 1'b1, 2'b00, 2'b10, 8'd3, 8'd0, 1'b1, 4'd8 },  // R8 zero leaves bits
        '{1'b1, 8'd3, 8'd4, 3'b001, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, 8'd3, 8'd0, 1'b0, 4'd10},  // R10 delay masked
        '{1'b0, 8'd3, 8'd4, 3'b001, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00, 8'd3, 8'd0, 1'b0, 4'd8 },  // R8 clear delay
        '{1'b0, 8'd3, 8'd4, 3'b001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 8'd2, 8'd4, 1'b0, 4'd2 },  // R2
        '{1'b0, 8'd3, 8'd4, 3'b001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 8'd1, 8'd4, 1'b0, 4'd2 },  // R2
        '{1'b0, 8'd3, 8'd4, 3'b001, 1'b1, 1'b0, 1'b1, 2'b01, 2'b01, 8'd3, 8'd4, 1'b1, 4'd9 },  // R9 set beats clear
        '{1'b1, 8'd2, 8'd0, 3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 8'd2, 8'd4, 1'b1, 4'd4 },  // R4 write beats completion
        '{1'b0, 8'd2, 8'd0, 3'b011, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 8'd1, 8'd4, 1'b1, 4'd5 },  // R5 zero delay leaves timer
        '{1'b0, 8'd2, 8'd0, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00, 2'b01, 8'd1, 8'd3, 1'b1, 4'd6 },  // R6
        '{1'b1, 8'd2, 8'd0, 3'b100, 1'b0, 1'b0, 1'b1, 2'b01, 2'b00, 8'd2, 8'd3, 1'b0, 4'd8 },  // R8 R4
        '{1'b0, 8'd2, 8'd0, 3'b100, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 8'd1, 8'd3, 1'b0, 4'd2 },  // R2
        '{1'b0, 8'd2, 8'd0, 3'b100, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 8'd2, 8'd3, 1'b0, 4'd10}   // R10 bit 14 has no source
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [1:0] ep, input logic [7:0] ec,
                           input logic [7:0] et, input logic ei);
        chk(tag, "pend", 32'(pend), 32'(ep));
        chk(tag, "cnt", 32'(cnt_live), 32'(ec));
        chk(tag, "tmr", 32'(tmr_live), 32'(et));
        chk(tag, "irq", 32'(irq), 32'(ei));
        chk(tag, "status", sts_rdata, {et, ec, 2'b00, ep, 12'h000});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        // R1 reset state, with a completion pulse held during reset
        pkt_done = 1'b1;
        repeat (3) @(negedge clk);
        chk_all("R1", 2'b00, 8'd1, 8'd0, 1'b0);
        pkt_done = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            ctrl_wr = VEC[v].cw;  cfg_thresh = VEC[v].thr; cfg_delay = VEC[v].dly;
            cfg_irq_en = VEC[v].en; pkt_done = VEC[v].pk;  tick = VEC[v].tk;
            sts_wr = VEC[v].sw;   sts_w1c = VEC[v].w1c;
            @(negedge clk);
            chk_all($sformatf("R%0d vec%0d", VEC[v].rq, v), VEC[v].e_pend,
                    VEC[v].e_cnt, VEC[v].e_tmr, VEC[v].e_irq);
        end
        ctrl_wr = 1'b0; pkt_done = 1'b0; tick = 1'b0; sts_wr = 1'b0;

        // R10 enabling bit 12 shows the still-pending completion
        cfg_irq_en = 3'b001;
        #1;
        chk("R10", "irq", 32'(irq), 32'd1);

        // R7 expiry reloads a partly used counter (threshold 2, delay 2)
        @(negedge clk);
        cfg_delay = 8'd2; pkt_done = 1'b1;          // cnt 2->1, tmr 2
        @(negedge clk);
        pkt_done = 1'b0; tick = 1'b1;               // tmr 1
        @(negedge clk);                             // tmr 0, expire
        @(negedge clk);
        tick = 1'b0;
        chk("R7", "cnt", 32'(cnt_live), 32'd2);
        chk("R7", "pend", 32'(pend), 32'd3);

        // R1 synchronous reset mid-run
        rst_n = 1'b0; pkt_done = 1'b1;
        @(negedge clk);
        chk_all("R1", 2'b00, 8'd1, 8'd0, 1'b0);
        pkt_done = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule